// File: doc/BRIEF.md
# Pass-Through Burst Write Consumer

This block sits on the add-on side of a bus bridge that forwards host write bursts through a pass-through window. It waits for the bridge to raise its active-low attention line. On that rising edge it samples four status lines: a burst flag, a 2-bit region number, a write flag and four active-low byte enables. For a write it then pulses a dedicated address-read strobe for one cycle and captures the latched host address from the shared data bus. In that same cycle it points its register select and register address at the bridge's data register.

It then holds the data-register read strobe and acknowledges words with an active-low ready. A word moves only on an edge where ready and attention are both low. Attention drops while the upstream initiator inserts wait states. A 2-bit throttle input adds 0 to 3 idle cycles after each accepted word, so a slow add-on can set its own rate. Each captured word leaves the block with a one-cycle valid pulse, together with the sampled byte enables, the region number and its position in the burst. The access ends when attention and burst are both seen high on the same edge. A read access is flagged as unsupported, and the block waits out its attention without touching the bus.

Top module: `pt_burst_consumer`

## Requirements
- R1: After reset, `selN`, `addrRdN`, `rdN` and `readyN` are high and `addrValid`, `wordValid` and `unsupported` are low.
- R2: From idle, a rising edge with `attnN` low and `wrFlag` high samples the status lines. In the next cycle `addrRdN` is low for exactly one cycle, and in that cycle `selN` is low and `regAddr` equals 0x2C.
- R3: The value on `dataBus` at the edge that ends the address-read cycle appears on `addrOut`, with `addrValid` high for one cycle right after that edge.
- R4: Throughout the streaming phase, which follows the address-read cycle, `rdN` and `selN` are low and `regAddr` equals 0x2C. `readyN` is never low outside that phase.
- R5: On a rising edge with `readyN` low and `attnN` low, the word on `dataBus` is captured. In the next cycle `wordValid` is high for one cycle and `wordData` carries that word. `wordBeN` and `wordRegion` carry the sampled status values (byte enables active low, 0h meaning all four bytes; region 01 meaning region 1). `wordIdx` counts from 0 at the first word of the access.
- R6: On an edge where `attnN` is high, no word is captured and `wordValid` is low in the next cycle, whatever `readyN` is.
- R7: After a word is captured, `readyN` stays high for exactly `throttle` cycles (0 to 3) and then goes low again. A throttle of 0 keeps `readyN` low, so one word can move per clock.
- R8: In streaming, an edge with `attnN` and `burstN` both high ends the access. In the next cycle `rdN`, `selN` and `readyN` are high, and a new access is accepted from that point.
- R9: If `wrFlag` is low when status is sampled, `unsupported` is high for one cycle. No strobe is driven and no word is output, and the block returns to idle on the first edge where `attnN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| attnN | input | 1 | Bridge attention, active low |
| burstN | input | 1 | Status: multi-word access, active low |
| regionNum | input | 2 | Status: pass-through region number |
| wrFlag | input | 1 | Status: access is a write |
| byteEnN | input | 4 | Status: byte enables, active low |
| throttle | input | 2 | Idle cycles inserted after each accepted word |
| dataBus | input | 32 | Bridge data bus (address, then data words) |
| selN | output | 1 | Register select to bridge, active low |
| regAddr | output | 8 | Bridge register address |
| addrRdN | output | 1 | Address-register read strobe, active low |
| rdN | output | 1 | Data-register read strobe, active low |
| readyN | output | 1 | Data-phase acknowledge, active low |
| addrValid | output | 1 | One-cycle pulse: addrOut is new |
| addrOut | output | 32 | Captured host address |
| wordValid | output | 1 | One-cycle pulse: captured word present |
| wordData | output | 32 | Captured data word |
| wordBeN | output | 4 | Byte enables of the access, active low |
| wordRegion | output | 2 | Region number of the access |
| wordIdx | output | 8 | Word position within the access, from 0 |
| unsupported | output | 1 | One-cycle pulse: read access refused |

## Verification
The critical overlap is an initiator stall that lands in the very cycle the throttle lets `readyN` fall again. A second case is a stall that arrives while `readyN` is held low at a throttle of 0. The bench drives attention from per-access stall masks chosen so that these collisions occur at several throttle settings. A behavioural model predicts, every cycle, whether a word is taken and which one. Any word taken during a stall, or any word lost when the stall clears, shows up as a mismatch in `wordValid`, `wordData` or `wordIdx`.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_STREAM = 2'd2,
    PH_DRAIN  = 2'd3
  } phase_t;

  // strobes from control to datapath, all one cycle wide
  typedef struct packed {
    logic latchStatus;
    logic loadAddr;
    logic takeWord;
    logic flagUnsup;
  } ctl_strobes_t;
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int GAP_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             attnN,
  input  logic             burstN,
  input  logic             wrFlag,
  input  logic [GAP_W-1:0] throttle,
  output ctl_strobes_t     strobes,
  output logic             addrPhase,
  output logic             streamPhase,
  output logic             readyOn
);
  phase_t phase, phaseNext;
  logic [GAP_W-1:0] gapCnt, gapNext;
  logic attnOn, endSeen, wordMove;

  assign attnOn   = !attnN;
  assign endSeen  = attnN && burstN;
  assign readyOn  = (phase == PH_STREAM) && (gapCnt == '0);
  assign wordMove = readyOn && attnOn && !endSeen;

  always_comb begin
    phaseNext = phase;
    gapNext   = gapCnt;
    strobes   = '0;
    unique case (phase)
      PH_IDLE: begin
        if (attnOn) begin
          strobes.latchStatus = 1'b1;
          if (wrFlag) begin
            phaseNext = PH_ADDR;
          end else begin
            phaseNext         = PH_DRAIN;
            strobes.flagUnsup = 1'b1;
          end
        end
      end
      PH_ADDR: begin
        strobes.loadAddr = 1'b1;
        phaseNext        = PH_STREAM;
        gapNext          = '0;
      end
      PH_STREAM: begin
        if (endSeen) begin
          phaseNext = PH_IDLE;
          gapNext   = '0;
        end else if (wordMove) begin
          strobes.takeWord = 1'b1;
          gapNext          = throttle;
        end else if (gapCnt != '0) begin
          gapNext = gapCnt - 1'b1;
        end
      end
      PH_DRAIN: begin
        if (!attnOn) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      gapCnt <= '0;
    end else begin
      phase  <= phaseNext;
      gapCnt <= gapNext;
    end
  end

  assign addrPhase   = (phase == PH_ADDR);
  assign streamPhase = (phase == PH_STREAM);
endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int BE_W     = DATA_W / 8,
  parameter int REGION_W = 2,
  parameter int IDX_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobes_t        strobes,
  input  logic [REGION_W-1:0] regionNum,
  input  logic [BE_W-1:0]     byteEnN,
  input  logic [DATA_W-1:0]   dataBus,
  output logic                addrValid,
  output logic [DATA_W-1:0]   addrOut,
  output logic                wordValid,
  output logic [DATA_W-1:0]   wordData,
  output logic [BE_W-1:0]     wordBeN,
  output logic [REGION_W-1:0] wordRegion,
  output logic [IDX_W-1:0]    wordIdx,
  output logic                unsupported
);
  logic [IDX_W-1:0] idxCnt;

  // status held for the whole access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordBeN    <= '1;
      wordRegion <= '0;
    end else if (strobes.latchStatus) begin
      wordBeN    <= byteEnN;
      wordRegion <= regionNum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      addrOut   <= '0;
    end else begin
      addrValid <= strobes.loadAddr;
      if (strobes.loadAddr) addrOut <= dataBus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordData  <= '0;
      wordIdx   <= '0;
      idxCnt    <= '0;
    end else begin
      wordValid <= strobes.takeWord;
      if (strobes.latchStatus) idxCnt <= '0;
      else if (strobes.takeWord) begin
        wordData <= dataBus;
        wordIdx  <= idxCnt;
        idxCnt   <= idxCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) unsupported <= 1'b0;
    else       unsupported <= strobes.flagUnsup;
  end
endmodule

// File: rtl/pt_burst_consumer.sv
module pt_burst_consumer
  import pt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int REGION_W   = 2,
  parameter int GAP_W      = 2,
  parameter int IDX_W      = 8,
  parameter int REG_ADDR_W = 8,
  parameter logic [REG_ADDR_W-1:0] REG_OFS = 8'h2C,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  attnN,
  input  logic                  burstN,
  input  logic [REGION_W-1:0]   regionNum,
  input  logic                  wrFlag,
  input  logic [BE_W-1:0]       byteEnN,
  input  logic [GAP_W-1:0]      throttle,
  input  logic [DATA_W-1:0]     dataBus,
  output logic                  selN,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic                  addrRdN,
  output logic                  rdN,
  output logic                  readyN,
  output logic                  addrValid,
  output logic [DATA_W-1:0]     addrOut,
  output logic                  wordValid,
  output logic [DATA_W-1:0]     wordData,
  output logic [BE_W-1:0]       wordBeN,
  output logic [REGION_W-1:0]   wordRegion,
  output logic [IDX_W-1:0]      wordIdx,
  output logic                  unsupported
);
  ctl_strobes_t strobes;
  logic addrPhase, streamPhase, readyOn;

  pt_ctrl #(.GAP_W(GAP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .attnN(attnN), .burstN(burstN),
    .wrFlag(wrFlag), .throttle(throttle), .strobes(strobes),
    .addrPhase(addrPhase), .streamPhase(streamPhase), .readyOn(readyOn)
  );

  pt_datapath #(.DATA_W(DATA_W), .BE_W(BE_W), .REGION_W(REGION_W), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regionNum(regionNum),
    .byteEnN(byteEnN), .dataBus(dataBus), .addrValid(addrValid),
    .addrOut(addrOut), .wordValid(wordValid), .wordData(wordData),
    .wordBeN(wordBeN), .wordRegion(wordRegion), .wordIdx(wordIdx),
    .unsupported(unsupported)
  );

  // bridge-side pins; the data register is selected from the address cycle on
  assign addrRdN = !addrPhase;
  assign selN    = !(addrPhase || streamPhase);
  assign regAddr = (addrPhase || streamPhase) ? REG_OFS : '0;
  assign rdN     = !streamPhase;
  assign readyN  = !readyOn;
endmodule

// File: rtl/pt_burst_consumer_chk.sv
module pt_burst_consumer_chk #(
  parameter int GAP_W      = 2,
  parameter int REG_ADDR_W = 8,
  parameter logic [REG_ADDR_W-1:0] REG_OFS = 8'h2C
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  attnN,
  input logic                  burstN,
  input logic [GAP_W-1:0]      throttle,
  input logic                  selN,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  addrRdN,
  input logic                  rdN,
  input logic                  readyN,
  input logic                  addrValid,
  input logic                  wordValid,
  input logic                  unsupported
);
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) !addrRdN |=> addrRdN); // R2
  AST_ADDR_SELECTS_DATA: assert property (@(posedge clk) disable iff (!rstN) !addrRdN |-> (!selN && regAddr == REG_OFS)); // R2
  AST_ADDR_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN) !addrRdN |=> addrValid); // R3
  AST_READY_IN_STREAM: assert property (@(posedge clk) disable iff (!rstN) !readyN |-> (!rdN && !selN && regAddr == REG_OFS)); // R4
  AST_WORD_TAKEN: assert property (@(posedge clk) disable iff (!rstN) (!readyN && !attnN) |=> wordValid); // R5
  AST_NO_WORD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN) attnN |=> !wordValid); // R6
  AST_THROTTLE_GAP: assert property (@(posedge clk) disable iff (!rstN) (!readyN && !attnN && throttle != '0) |=> readyN); // R7
  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rstN) (!rdN && attnN && burstN) |=> (rdN && selN && readyN)); // R8
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rstN) unsupported |-> (readyN && addrRdN && rdN)); // R9
endmodule

bind pt_burst_consumer pt_burst_consumer_chk #(
  .GAP_W(GAP_W), .REG_ADDR_W(REG_ADDR_W), .REG_OFS(REG_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .attnN(attnN), .burstN(burstN), .throttle(throttle),
  .selN(selN), .regAddr(regAddr), .addrRdN(addrRdN), .rdN(rdN), .readyN(readyN),
  .addrValid(addrValid), .wordValid(wordValid), .unsupported(unsupported)
);

// File: tb/tb_pt_burst_consumer.sv
`timescale 1ns/1ps
module tb_pt_burst_consumer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic attnN = 1'b1, burstN = 1'b1, wrFlag = 1'b0;
  logic [1:0] regionNum = 2'd0, throttle = 2'd0;
  logic [3:0] byteEnN = 4'hF;
  logic [31:0] dataBus;
  logic selN, addrRdN, rdN, readyN, addrValid, wordValid, unsupported;
  logic [7:0] regAddr, wordIdx;
  logic [31:0] addrOut, wordData;
  logic [3:0] wordBeN;
  logic [1:0] wordRegion;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pt_burst_consumer dut (
    .clk(clk), .rstN(rstN), .attnN(attnN), .burstN(burstN), .regionNum(regionNum),
    .wrFlag(wrFlag), .byteEnN(byteEnN), .throttle(throttle), .dataBus(dataBus),
    .selN(selN), .regAddr(regAddr), .addrRdN(addrRdN), .rdN(rdN), .readyN(readyN),
    .addrValid(addrValid), .addrOut(addrOut), .wordValid(wordValid), .wordData(wordData),
    .wordBeN(wordBeN), .wordRegion(wordRegion), .wordIdx(wordIdx), .unsupported(unsupported)
  );

  // ---------------- bridge model ----------------
  logic [31:0] bWords [0:15];
  logic [31:0] bAddr = 32'h0;
  int bN = 0, bPtr = 0;
  bit bActive = 1'b0;
  int gotWords = 0;

  always @* begin
    if (!addrRdN) dataBus = bAddr;
    else if (!rdN && !selN && regAddr == 8'h2C && !attnN && bPtr < bN) dataBus = bWords[bPtr];
    else dataBus = 32'hDEAD_BEEF;
  end

  always @(posedge clk) begin
    if (bActive && wrFlag && !readyN && !attnN) bPtr <= bPtr + 1;
  end

  // ---------------- reference model ----------------
  int mSt = 0, mGap = 0, mIdx = 0;
  bit eAddrValid = 0, eWordValid = 0, eUnsup = 0;
  logic [31:0] eAddr = 0, eWord = 0;
  logic [7:0] eIdx = 0;
  logic [3:0] eBe = 4'hF;
  logic [1:0] eRegion = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mGap = 0; mIdx = 0;
      eAddrValid = 0; eWordValid = 0; eUnsup = 0;
      eAddr = 0; eWord = 0; eIdx = 0; eBe = 4'hF; eRegion = 0;
    end else begin
      eAddrValid = 0; eWordValid = 0; eUnsup = 0;
      if (mSt == 0) begin
        if (!attnN) begin
          eBe = byteEnN; eRegion = regionNum; mIdx = 0;
          if (wrFlag) mSt = 1;
          else begin mSt = 3; eUnsup = 1; end
        end
      end else if (mSt == 1) begin
        eAddr = dataBus; eAddrValid = 1; mSt = 2; mGap = 0;
      end else if (mSt == 2) begin
        if (attnN && burstN) begin mSt = 0; mGap = 0; end
        else if (mGap == 0 && !attnN) begin
          eWordValid = 1; eWord = dataBus; eIdx = 8'(mIdx); mIdx++; mGap = throttle;
        end else if (mGap > 0) mGap--;
      end else begin
        if (attnN) mSt = 0;
      end
    end
  end

  task automatic chk1(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk1("R2", "addrRdN", 32'(addrRdN), 32'(mSt != 1));
      chk1("R4", "selN", 32'(selN), 32'(!(mSt == 1 || mSt == 2)));
      chk1("R4", "rdN", 32'(rdN), 32'(mSt != 2));
      if (mSt == 1 || mSt == 2) chk1("R4", "regAddr", 32'(regAddr), 32'h2C);
      chk1("R7", "readyN", 32'(readyN), 32'(!(mSt == 2 && mGap == 0)));
      chk1("R3", "addrValid", 32'(addrValid), 32'(eAddrValid));
      if (eAddrValid) chk1("R3", "addrOut", addrOut, eAddr);
      chk1("R6", "wordValid", 32'(wordValid), 32'(eWordValid));
      if (eWordValid) begin
        chk1("R5", "wordData", wordData, eWord);
        chk1("R5", "wordIdx", 32'(wordIdx), 32'(eIdx));
        chk1("R5", "wordBeN", 32'(wordBeN), 32'(eBe));
        chk1("R5", "wordRegion", 32'(wordRegion), 32'(eRegion));
      end
      chk1("R9", "unsupported", 32'(unsupported), 32'(eUnsup));
      if (wordValid) gotWords++;
    end
  end

  task automatic runAccess(int n, bit isBurst, bit isWr, logic [1:0] reg_, logic [3:0] be,
                           logic [63:0] stallMask, logic [1:0] thr, logic [31:0] seed);
    int cyc = 0;
    int startWords;
    @(negedge clk);
    startWords = gotWords;
    for (int i = 0; i < 16; i++) bWords[i] = seed + 32'(i) * 32'h0101_0103;
    bAddr = seed ^ 32'hA5A0_0000;
    bN = n; bPtr = 0; bActive = 1'b1;
    throttle = thr; wrFlag = isWr; regionNum = reg_; byteEnN = be;
    burstN = !isBurst; attnN = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if ((isWr && bPtr >= bN) || (!isWr && cyc >= 4)) begin
        attnN = 1'b1; burstN = 1'b1;
        break;
      end
      attnN = stallMask[cyc % 64];
    end
    repeat (3) @(negedge clk);
    bActive = 1'b0;
    chk1(isWr ? "R8" : "R9", "words delivered", 32'(gotWords - startWords), isWr ? 32'(n) : 32'd0);
    chk1("R8", "idle strobes", 32'({selN, rdN, readyN, addrRdN}), 32'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk1("R1", "strobes in reset", 32'({selN, addrRdN, rdN, readyN}), 32'hF);
    chk1("R1", "pulses in reset", 32'({addrValid, wordValid, unsupported}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk1("R1", "strobes after reset", 32'({selN, addrRdN, rdN, readyN}), 32'hF);
    runAccess(6, 1, 1, 2'b01, 4'h0, 64'h0000_0000_0000_0C60, 2'd0, 32'h1000_0000);
    runAccess(5, 1, 1, 2'b01, 4'h0, 64'h0, 2'd1, 32'h2000_0010);
    runAccess(4, 1, 1, 2'b11, 4'h0, 64'h0000_0000_0000_0090, 2'd3, 32'h3000_0020);
    runAccess(1, 0, 1, 2'b10, 4'hC, 64'h0, 2'd2, 32'h4000_0030);
    runAccess(0, 1, 0, 2'b01, 4'h0, 64'h0, 2'd0, 32'h5000_0040);
    runAccess(8, 1, 1, 2'b00, 4'h3, 64'h0000_0000_0000_02A8, 2'd2, 32'h6000_0050);
    runAccess(7, 1, 1, 2'b01, 4'h0, 64'h0000_0000_0000_1554, 2'd1, 32'h7000_0060);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule